// File: doc/BRIEF.md
# Radix-2 SRT Unsigned Integer Divider

This block divides one unsigned integer by another over several clocks using radix-2 SRT iteration. Quotient digits come from the set {-1, 0, +1}. A one-cycle `start` strobe presents an N-bit dividend and an N-bit divisor. The block then shifts both operands left by the divisor's leading-zero count. Each SRT step picks a digit by looking only at the three most significant bits of a 2N+1-bit partial remainder. Positive digits are collected in the vacated low bits of that remainder, and negative digits in a separate register.

After the last step the redundant quotient is collapsed to binary. If the final partial remainder is negative, the quotient is decremented by one and the divisor is added back to the remainder. The remainder is then shifted right by the normalization amount, and a `done` pulse is raised with both results.

A parameter sets how many SRT steps are chained inside one clock, and the latency shrinks in proportion. A zero divisor is detected up front: no iteration runs, and a flagged result is returned on the next edge.

Top module: `srt_divider`

## Requirements
- R1: While reset (`rstN` low) is applied, and directly after it, `busy`, `done`, `divByZero`, `quotient` and `remainder` are all zero.
- R2: For a nonzero divisor, the reported `quotient` is floor(dividend / divisor), the reported `remainder` is dividend mod divisor, and `divByZero` is 0.
- R3: For a nonzero divisor, `done` is high for exactly one cycle, ITER+1 rising edges after the edge that samples `start`, where ITER = DATA_W / STEPS.
- R4: `busy` rises on the edge that accepts `start` and falls on the edge where `done` rises. A `start` seen while `busy` is high is ignored and does not change the results of the division in progress.
- R5: For a zero divisor, `done` pulses on the first edge after `start`, with `quotient` all ones, `remainder` equal to the dividend and `divByZero` = 1. `busy` stays low.
- R6: `quotient`, `remainder` and `divByZero` keep their values from one `done` until the next accepted division completes, whatever the operand inputs do.
- R7: Results are correct for divisors of every leading-zero count: divisor 1, divisor with its top bit set, dividend smaller than divisor (quotient 0), and dividend equal to divisor.
- R8: A `start` presented in the cycle where `done` is high is accepted and begins a new division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when the block is idle |
| dividend | input | DATA_W | Unsigned dividend, sampled with `start` |
| divisor | input | DATA_W | Unsigned divisor, sampled with `start` |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | DATA_W | Unsigned quotient |
| remainder | output | DATA_W | Unsigned remainder |
| divByZero | output | 1 | The last division had a zero divisor |

## Verification
A zero-divisor result is due one rising edge after the edge that accepts `start`. A normal result is due ITER+1 edges after that edge, and `busy` is high for exactly the edges in between. The bench holds a behavioural model that counts those edges from the inputs it sees at each rising edge. Outputs are compared on every falling edge, halfway between edges, so each expected value is checked in the cycle where it must first appear and again in every later cycle while it has to hold. The stimulus includes a start held through a busy period and a start issued in the same cycle as `done`, so the edge-counting model must decide acceptance exactly as R4 and R8 state.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef struct packed {
    logic load;     // capture normalized operands
    logic step;     // run STEPS SRT iterations
    logic finish;   // convert, correct, denormalize, register results
    logic zeroFin;  // register the divide-by-zero result
  } srtCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } srtState_t;

endpackage

// File: rtl/srt_lzc.sv
module srt_lzc #(
  parameter int WIDTH = 8,
  localparam int KW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] value,
  output logic [KW-1:0]    zeros
);

  // The highest set bit wins because it is visited last.
  always_comb begin
    zeros = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (value[i]) zeros = KW'(WIDTH - 1 - i);
    end
  end

endmodule

// File: rtl/srt_step.sv
module srt_step #(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH + 1
) (
  input  logic [PW-1:0]    pIn,
  input  logic [WIDTH-1:0] negIn,
  input  logic [WIDTH-1:0] normDiv,
  output logic [PW-1:0]    pOut,
  output logic [WIDTH-1:0] negOut
);

  logic [2:0]    top3;
  logic [PW-1:0] shifted;
  logic [PW-1:0] divAligned;

  assign top3       = pIn[PW-1:PW-3];
  assign shifted    = {pIn[PW-2:0], 1'b0};
  assign divAligned = {1'b0, normDiv, {WIDTH{1'b0}}};

  always_comb begin
    unique case (top3)
      3'b000, 3'b111: begin
        pOut   = shifted;
        negOut = {negIn[WIDTH-2:0], 1'b0};
      end
      3'b100, 3'b101, 3'b110: begin
        pOut   = shifted + divAligned;
        negOut = {negIn[WIDTH-2:0], 1'b1};
      end
      default: begin
        // Positive digit goes into the freshly vacated LSB.
        pOut   = (shifted | PW'(1)) - divAligned;
        negOut = {negIn[WIDTH-2:0], 1'b0};
      end
    endcase
  end

endmodule

// File: rtl/srt_datapath.sv
module srt_datapath
  import srt_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int STEPS = 1,
  localparam int PW = 2 * WIDTH + 1,
  localparam int KW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  srtCtrl_t         ctrl,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotQ,
  output logic [WIDTH-1:0] remQ,
  output logic             zeroQ
);

  logic [PW-1:0]    pRem;
  logic [WIDTH-1:0] negDig;
  logic [WIDTH-1:0] normDiv;
  logic [KW-1:0]    shiftK;
  logic [KW-1:0]    lzCount;

  srt_lzc #(.WIDTH(WIDTH)) uLzc (
    .value (divisor),
    .zeros (lzCount)
  );

  // Chain of STEPS combinational SRT stages.
  logic [PW-1:0]    stageP   [0:STEPS];
  logic [WIDTH-1:0] stageNeg [0:STEPS];

  assign stageP[0]   = pRem;
  assign stageNeg[0] = negDig;

  for (genvar s = 0; s < STEPS; s++) begin : gStage
    srt_step #(.WIDTH(WIDTH)) uStep (
      .pIn     (stageP[s]),
      .negIn   (stageNeg[s]),
      .normDiv (normDiv),
      .pOut    (stageP[s+1]),
      .negOut  (stageNeg[s+1])
    );
  end

  // Final conversion and correction.
  logic [WIDTH-1:0] posDig;
  logic [WIDTH:0]   rawRem;
  logic [WIDTH:0]   corrRem;
  logic [WIDTH-1:0] corrQuot;
  logic [WIDTH-1:0] remOut;

  assign posDig = pRem[WIDTH-1:0];
  assign rawRem = pRem[PW-1:WIDTH];

  always_comb begin
    if (pRem[PW-1]) begin
      corrRem  = rawRem + {1'b0, normDiv};
      corrQuot = posDig - negDig - WIDTH'(1);
    end else begin
      corrRem  = rawRem;
      corrQuot = posDig - negDig;
    end
    remOut = corrRem[WIDTH-1:0] >> shiftK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pRem    <= '0;
      negDig  <= '0;
      normDiv <= '0;
      shiftK  <= '0;
    end else if (ctrl.load) begin
      pRem    <= {{(WIDTH+1){1'b0}}, dividend} << lzCount;
      negDig  <= '0;
      normDiv <= divisor << lzCount;
      shiftK  <= lzCount;
    end else if (ctrl.step) begin
      pRem    <= stageP[STEPS];
      negDig  <= stageNeg[STEPS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotQ <= '0;
      remQ  <= '0;
      zeroQ <= 1'b0;
    end else if (ctrl.zeroFin) begin
      quotQ <= '1;
      remQ  <= dividend;
      zeroQ <= 1'b1;
    end else if (ctrl.finish) begin
      quotQ <= corrQuot;
      remQ  <= remOut;
      zeroQ <= 1'b0;
    end
  end

  // R7: normalization leaves the divisor MSB set.
  a_r7_normalized: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> normDiv[WIDTH-1]);

  // R2: corrected remainder is nonnegative and below the normalized divisor.
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.finish |-> (!corrRem[WIDTH] && (corrRem < {1'b0, normDiv})));

  // R5: zero divisor result.
  a_r5_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.zeroFin |=> (zeroQ && (&quotQ)));

  // R6: results hold unless a result strobe fired.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.finish || ctrl.zeroFin) |=> ($stable(quotQ) && $stable(remQ) && $stable(zeroQ)));

endmodule

// File: rtl/srt_control.sv
module srt_control
  import srt_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int STEPS = 1,
  localparam int ITER = WIDTH / STEPS,
  localparam int CW = $clog2(ITER + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     divisorZero,
  output srtCtrl_t ctrl,
  output logic     busy,
  output logic     done
);

  srtState_t state;
  logic [CW-1:0] count;

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_IDLE: begin
        ctrl.load    = start && !divisorZero;
        ctrl.zeroFin = start && divisorZero;
      end
      ST_RUN:  ctrl.step   = 1'b1;
      ST_FIN:  ctrl.finish = 1'b1;
      default: ctrl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= ctrl.finish || ctrl.zeroFin;
      unique case (state)
        ST_IDLE: begin
          count <= '0;
          if (ctrl.load) state <= ST_RUN;
        end
        ST_RUN: begin
          count <= count + CW'(1);
          if (count == CW'(ITER - 1)) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R4: done never coincides with busy.
  a_r4_busy_no_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  // R4: a new operand load only happens from idle.
  a_r4_load_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |-> (state == ST_IDLE));

  // R3: iteration counter stays inside the step budget.
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (count < CW'(ITER)));

  // R3: finishing always follows the last step.
  a_r3_fin_after_run: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN) |-> ($past(state) == ST_RUN));

  // R3: done is followed by a non-busy cycle of its own pulse.
  a_r3_done_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN) |=> (done && !busy));

endmodule

// File: rtl/srt_divider.sv
module srt_divider
  import srt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STEPS  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              divByZero
);

  srtCtrl_t ctrl;

  srt_control #(.WIDTH(DATA_W), .STEPS(STEPS)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .divisorZero (divisor == '0),
    .ctrl        (ctrl),
    .busy        (busy),
    .done        (done)
  );

  srt_datapath #(.WIDTH(DATA_W), .STEPS(STEPS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dividend (dividend),
    .divisor  (divisor),
    .quotQ    (quotient),
    .remQ     (remainder),
    .zeroQ    (divByZero)
  );

endmodule

// File: tb/tb_srt_divider.sv
module tb_srt_divider;

  localparam int N    = 8;
  localparam int M    = 2;
  localparam int ITER = N / M;
  localparam int MAXV = (1 << N) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic busy, done, divByZero;
  logic [N-1:0] quotient, remainder;

  srt_divider #(.DATA_W(N), .STEPS(M)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .divByZero(divByZero)
  );

  always #10 clk = ~clk;  // 50 MHz

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Behavioural reference model, advanced at each rising edge.
  int  cnt = 0;
  int  pendQ = 0, pendR = 0;
  int  expQ = 0, expR = 0;
  bit  expBusy = 0, expDone = 0, expZ = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt = 0; expQ = 0; expR = 0; expBusy = 0; expDone = 0; expZ = 0;
    end else begin
      expDone = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          expDone = 1; expBusy = 0; expQ = pendQ; expR = pendR; expZ = 0;
        end
      end else if (start) begin
        if (divisor == 0) begin
          expDone = 1; expQ = MAXV; expR = int'(dividend); expZ = 1;
        end else begin
          cnt = ITER + 1; expBusy = 1;
          pendQ = int'(dividend) / int'(divisor);
          pendR = int'(dividend) % int'(divisor);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every falling edge.
  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        check(busy == 0 && done == 0 && divByZero == 0 && quotient == 0 && remainder == 0,
              "R1 reset outputs", int'({busy, done, divByZero, quotient, remainder}), 0);
      end else begin
        check(busy == expBusy, "R4 busy", int'(busy), int'(expBusy));
        check(done == expDone, "R3 done timing", int'(done), int'(expDone));
        check(divByZero == expZ, "R5 divByZero flag", int'(divByZero), int'(expZ));
        if (expZ)
          check(int'(quotient) == expQ && int'(remainder) == expR, "R5 zero-divisor result",
                int'(quotient) * 1000 + int'(remainder), expQ * 1000 + expR);
        else if (expDone)
          check(int'(quotient) == expQ && int'(remainder) == expR, "R2 quotient/remainder",
                int'(quotient) * 1000 + int'(remainder), expQ * 1000 + expR);
        else
          check(int'(quotient) == expQ && int'(remainder) == expR, "R6 held results",
                int'(quotient) * 1000 + int'(remainder), expQ * 1000 + expR);
      end
    end
  end

  task automatic waitIdle();
    while (busy || done) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic runDiv(input int a, input int b);
    waitIdle();
    dividend = N'(a); divisor = N'(b); start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    // Scramble operands during the run (R6: no effect on results).
    dividend = ~N'(a); divisor = N'(b) ^ 8'h5A;
    while (!done) begin
      @(posedge clk); #2;
    end
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(posedge clk); #2;

    // R2 / R7: directed cases covering leading-zero counts.
    runDiv(200, 7);
    runDiv(255, 1);      // R7 divisor 1
    runDiv(255, 255);    // R7 equal operands
    runDiv(3, 200);      // R7 quotient 0
    runDiv(0, 5);
    runDiv(128, 128);
    runDiv(1, 255);
    runDiv(254, 128);    // R7 divisor top bit set
    runDiv(255, 16);
    runDiv(97, 3);

    // R5: zero divisor.
    runDiv(100, 0);
    runDiv(255, 0);
    runDiv(0, 0);

    // R4: start held high while busy with other operands; ignored.
    waitIdle();
    dividend = 8'd250; divisor = 8'd9; start = 1'b1;
    @(posedge clk); #2;
    dividend = 8'd17; divisor = 8'd0;
    repeat (ITER) begin @(posedge clk); #2; end
    start = 1'b0;
    repeat (ITER + 4) begin @(posedge clk); #2; end

    // R8: start in the cycle where done is high.
    runDiv(221, 13);
    dividend = 8'd143; divisor = 8'd11; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    while (!done) begin @(posedge clk); #2; end
    dividend = 8'd7; divisor = 8'd0; start = 1'b1;   // zero divide straight after done
    @(posedge clk); #2;
    start = 1'b0;
    repeat (3) begin @(posedge clk); #2; end

    // R2: random operands.
    for (int i = 0; i < 1500; i++) begin
      int a, b;
      a = int'($urandom_range(MAXV, 0));
      b = int'($urandom_range(MAXV, 1));
      if (i % 50 == 0) b = 0;
      runDiv(a, b);
    end
    waitIdle();
    repeat (3) begin @(posedge clk); #2; end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule